// File: doc/BRIEF.md
# Dual-Increment Phase Accumulator for Direct Digital Synthesis

This block is the phase engine of a direct digital synthesis generator. A 48-bit phase register advances on every clock by a frequency word, so the output frequency is proportional to that word. The frequency word comes from one of two increment registers, A and B. A select input picks which one feeds the adder, and a change of selection takes effect at the very next clock edge. The upper bits of the phase register form the address of an external waveform table. The address is two bits wider than the DAC word that the table feeds, which keeps phase quantization below the DAC's own error.

An external controller loads each increment register one byte at a time into a shadow copy. A commit strobe then moves the whole 48-bit shadow value into the working register. The controller may load and commit the register that is not selected while the selected one keeps driving the adder. This supports ping-pong frequency hopping without glitches. It also supports phase modulation: B holds A plus an offset and is selected for exactly one clock. A load or commit aimed at the selected register is refused and flagged.

Top module: `dds_phase_acc`

## Requirements
- R1: While rst_ni is low, phase_o, addr_o and wr_err_o are zero, and both working increments and both shadows are zero. After release with no commit, the phase stays at zero.
- R2: At every clock edge, phase_o becomes its previous value plus the selected working increment, modulo 2^48. No carry is output.
- R3: addr_o always equals the top ADDR_W bits of phase_o, where ADDR_W = DAC_W + 2 (phase_o[47:34] by default).
- R4: The value of sel_i at an edge chooses the increment for that edge's addition (0 selects A, 1 selects B). A change of sel_i therefore takes effect in one clock.
- R5: A byte write with wr_en_i high and wr_sel_i naming a register (0 = A, 1 = B) stores wr_data_i into bits [8k+7:8k] of that register's shadow, where k = wr_byte_idx_i. Index values 6 and 7 are ignored.
- R6: A shadow value has no effect on the phase until commit_i is pulsed for that register. The commit copies all 48 bits at once, and the new increment is used from the next edge onward.
- R7: A byte write or commit whose wr_sel_i equals sel_i at that edge is ignored. wr_err_o is then high for exactly the one cycle that follows. Otherwise wr_err_o is low.
- R8: Loading and committing the register that is not selected leaves the current step of the phase unchanged.
- R9: When B holds A plus an offset and B is selected for one clock, the phase ends up advanced by exactly that offset compared with running on A alone.
- R10: When a commit and a byte write to the same register fall on the same edge, the commit takes the shadow as it stood before that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | DDS clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe to a shadow register |
| wr_sel_i | input | 1 | Target of the write or commit: 0 = A, 1 = B |
| wr_byte_idx_i | input | 3 | Byte lane, 0 = least significant |
| wr_data_i | input | 8 | Byte value to store |
| commit_i | input | 1 | Copy the target's shadow into its working register |
| sel_i | input | 1 | Increment feeding the adder: 0 = A, 1 = B |
| phase_o | output | 48 | Phase accumulator |
| addr_o | output | 14 | Waveform table address (top phase bits) |
| wr_err_o | output | 1 | One-cycle flag for a refused write or commit |

## Verification
Every result is registered once. phase_o, addr_o and wr_err_o show the outcome of the inputs sampled at an edge directly after that edge. A committed increment can first affect the phase one edge after its commit. The bench drives its inputs on the falling edge and keeps a behavioural model that it advances on each rising edge. It compares all three outputs against the model at the following falling edge, so every cycle is checked at the point where its result is due. In addition, it checks the phase-hop offset and the refusal flag explicitly at the cycle where each is expected.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam int unsigned DEF_ACC_W  = 48;
  localparam int unsigned DEF_DAC_W  = 12;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned NUM_INC    = 2;

  typedef enum logic {
    INC_A = 1'b0,
    INC_B = 1'b1
  } inc_sel_e;
endpackage

// File: rtl/dds_wr_gate.sv
module dds_wr_gate
  import dds_pkg::*;
#(
  parameter int unsigned NUM_BYTES = 6,
  parameter int unsigned BIDX_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BIDX_W-1:0] wr_byte_idx_i,
  input  logic              commit_i,
  input  logic              sel_i,
  output logic [NUM_INC-1:0] byte_we_o,
  output logic [NUM_INC-1:0] commit_o,
  output logic              wr_err_o
);
  logic hits_active;
  logic idx_ok;
  logic err_q;

  assign hits_active = (wr_sel_i == sel_i);
  assign idx_ok      = int'(wr_byte_idx_i) < int'(NUM_BYTES);

  for (genvar g = 0; g < NUM_INC; g++) begin : g_lane
    logic target;
    assign target       = (wr_sel_i == g[0]) && !hits_active;
    assign byte_we_o[g] = wr_en_i && idx_ok && target;
    assign commit_o[g]  = commit_i && target;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= (wr_en_i || commit_i) && hits_active;
  end

  assign wr_err_o = err_q;
endmodule

// File: rtl/dds_inc_bank.sv
module dds_inc_bank #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned BIDX_W = 3,
  localparam int unsigned NUM_BYTES = ACC_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [BIDX_W-1:0] byte_idx_i,
  input  logic [BYTE_W-1:0] byte_data_i,
  input  logic              commit_i,
  output logic [ACC_W-1:0]  active_o
);
  logic [ACC_W-1:0] shadow_q;
  logic [ACC_W-1:0] active_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shadow_q[b*BYTE_W +: BYTE_W] <= '0;
      end else if (byte_we_i && byte_idx_i == BIDX_W'(b)) begin
        shadow_q[b*BYTE_W +: BYTE_W] <= byte_data_i;
      end
    end
  end

  // commit samples the pre-edge shadow, so a same-edge byte lands afterwards
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       active_q <= '0;
    else if (commit_i) active_q <= shadow_q;
  end

  assign active_o = active_q;
endmodule

// File: rtl/dds_accum.sv
module dds_accum #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned ADDR_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic [ACC_W-1:0]  inc_a_i,
  input  logic [ACC_W-1:0]  inc_b_i,
  output logic [ACC_W-1:0]  phase_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ACC_W-1:0] step;
  logic [ACC_W-1:0] phase_q;

  assign step = sel_i ? inc_b_i : inc_a_i;

  // modulo 2^ACC_W: carry out is discarded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_q + step;
  end

  assign phase_o = phase_q;
  assign addr_o  = phase_q[ACC_W-1 -: ADDR_W];
endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc
  import dds_pkg::*;
#(
  parameter int unsigned ACC_W  = DEF_ACC_W,
  parameter int unsigned DAC_W  = DEF_DAC_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned ADDR_W    = DAC_W + 2,
  localparam int unsigned NUM_BYTES = ACC_W / BYTE_W,
  localparam int unsigned BIDX_W    = $clog2(NUM_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [BIDX_W-1:0] wr_byte_idx_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              commit_i,
  input  logic              sel_i,
  output logic [ACC_W-1:0]  phase_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_err_o
);
  logic [NUM_INC-1:0] byte_we;
  logic [NUM_INC-1:0] commit;
  logic [ACC_W-1:0]   inc_act [NUM_INC];

  dds_wr_gate #(
    .NUM_BYTES(NUM_BYTES),
    .BIDX_W   (BIDX_W)
  ) i_wr_gate (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_sel_i     (wr_sel_i),
    .wr_byte_idx_i(wr_byte_idx_i),
    .commit_i     (commit_i),
    .sel_i        (sel_i),
    .byte_we_o    (byte_we),
    .commit_o     (commit),
    .wr_err_o     (wr_err_o)
  );

  for (genvar g = 0; g < NUM_INC; g++) begin : g_bank
    dds_inc_bank #(
      .ACC_W (ACC_W),
      .BYTE_W(BYTE_W),
      .BIDX_W(BIDX_W)
    ) i_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .byte_we_i  (byte_we[g]),
      .byte_idx_i (wr_byte_idx_i),
      .byte_data_i(wr_data_i),
      .commit_i   (commit[g]),
      .active_o   (inc_act[g])
    );
  end

  dds_accum #(
    .ACC_W (ACC_W),
    .ADDR_W(ADDR_W)
  ) i_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .inc_a_i(inc_act[INC_A]),
    .inc_b_i(inc_act[INC_B]),
    .phase_o(phase_o),
    .addr_o (addr_o)
  );
endmodule

// File: rtl/dds_phase_acc_chk.sv
module dds_phase_acc_chk #(
  parameter int unsigned ACC_W = 48
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             wr_sel_i,
  input logic             commit_i,
  input logic             sel_i,
  input logic [ACC_W-1:0] phase_o,
  input logic             wr_err_o,
  input logic [ACC_W-1:0] inc_a,
  input logic [ACC_W-1:0] inc_b
);
  p_refuse_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_en_i || commit_i) && wr_sel_i == sel_i) |=> wr_err_o);

  p_no_spurious_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((wr_en_i || commit_i) && wr_sel_i == sel_i) |=> !wr_err_o);

  p_active_a_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 1'b0) |=> $stable(inc_a));

  p_active_b_held_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 1'b1) |=> $stable(inc_b));

  p_commit_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> ($stable(inc_a) && $stable(inc_b)));

  p_accum_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> phase_o == ACC_W'($past(phase_o) + ($past(sel_i) ? $past(inc_b) : $past(inc_a))));
endmodule

bind dds_phase_acc dds_phase_acc_chk #(.ACC_W(ACC_W)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_en_i (wr_en_i),
  .wr_sel_i(wr_sel_i),
  .commit_i(commit_i),
  .sel_i   (sel_i),
  .phase_o (phase_o),
  .wr_err_o(wr_err_o),
  .inc_a   (inc_act[0]),
  .inc_b   (inc_act[1])
);

// File: tb/test_dds_phase_acc.sv
module test_dds_phase_acc;
  localparam int CLK_PERIOD = 10;
  localparam int ACC_W  = 48;
  localparam int ADDR_W = 14;
  localparam int WDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en = 1'b0, wr_sel = 1'b0, commit = 1'b0, sel = 1'b0;
  logic [2:0]        widx = '0;
  logic [7:0]        wdata = '0;
  logic [ACC_W-1:0]  phase;
  logic [ADDR_W-1:0] addr;
  logic              werr;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference
  logic [ACC_W-1:0] m_phase = '0;
  logic [ACC_W-1:0] m_sh  [2] = '{default: '0};
  logic [ACC_W-1:0] m_act [2] = '{default: '0};
  logic             m_err = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dds_phase_acc i_dds_phase_acc (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_byte_idx_i(widx), .wr_data_i(wdata), .commit_i(commit), .sel_i(sel),
    .phase_o(phase), .addr_o(addr), .wr_err_o(werr)
  );

  task automatic chk(input string tag, input logic [ACC_W-1:0] act, input logic [ACC_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input string tag, input logic s, input logic we = 1'b0,
                     input logic ws = 1'b0, input int idx = 0,
                     input logic [7:0] d = '0, input logic cm = 1'b0);
    logic [ACC_W-1:0] step;
    logic refused;
    wr_en = we; wr_sel = ws; widx = 3'(idx); wdata = d; commit = cm; sel = s;
    @(posedge clk);
    step    = m_act[s];
    refused = (we || cm) && (ws == s);
    m_err   = refused;
    if (!refused) begin
      if (cm) m_act[ws] = m_sh[ws];
      if (we && idx < 6) m_sh[ws][idx*8 +: 8] = d;
    end
    m_phase = m_phase + step;
    @(negedge clk);
    chk({tag, " R2 phase"}, phase, m_phase);
    chk({tag, " R3 addr"}, ACC_W'(addr), ACC_W'(m_phase[ACC_W-1 -: ADDR_W]));
    chk({tag, " R7 err"}, ACC_W'(werr), ACC_W'(m_err));
  endtask

  task automatic load(input string tag, input logic s, input logic ws, input logic [ACC_W-1:0] v);
    for (int k = 0; k < 6; k++) cyc(tag, s, 1'b1, ws, k, v[k*8 +: 8]);
  endtask

  initial begin : wdog
    for (int n = 0; n < WDOG && !done; n++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ACC_W-1:0] base, hop;
    // R1: reset values
    repeat (3) @(negedge clk);
    chk("R1 phase in reset", phase, '0);
    chk("R1 addr in reset", ACC_W'(addr), '0);
    chk("R1 err in reset", ACC_W'(werr), '0);
    rst_ni = 1'b1;
    repeat (3) cyc("R1 idle", 1'b0);

    // R5/R6: load A while B is selected, shadow stays invisible
    load("R5 load A", 1'b1, 1'b0, 48'h0123_4567_89AB);
    repeat (2) cyc("R6 uncommitted A", 1'b0);
    chk("R6 phase untouched before commit", phase, '0);
    cyc("R6 commit A", 1'b1, 1'b0, 1'b0, 0, 8'h0, 1'b1);
    repeat (8) cyc("R2 run A", 1'b0);
    chk("R6 A in use", phase, ACC_W'(48'h0123_4567_89AB * 8));

    // R7: write and commit at active A refused
    cyc("R7 write active", 1'b0, 1'b1, 1'b0, 0, 8'hFF);
    chk("R7 flag after refused write", ACC_W'(werr), 1);
    cyc("R7 flag clears", 1'b0);
    chk("R7 flag one cycle", ACC_W'(werr), 0);
    cyc("R7 commit active", 1'b0, 1'b0, 1'b0, 0, 8'h0, 1'b1);
    repeat (3) cyc("R7 A unchanged", 1'b0);

    // R8/R5: load B while A runs; index 6 ignored
    load("R8 load B", 1'b0, 1'b1, 48'hF000_0000_0001);
    cyc("R5 idx6 ignored", 1'b0, 1'b1, 1'b1, 6, 8'h77);
    cyc("R5 idx7 ignored", 1'b0, 1'b1, 1'b1, 7, 8'h66);
    cyc("R8 commit B", 1'b0, 1'b0, 1'b1, 0, 8'h0, 1'b1);
    // R4/R2: switch to B, large step forces wrap
    repeat (10) cyc("R4 run B wrap", 1'b1);
    repeat (2) cyc("R4 back to A", 1'b0);

    // R10: commit and write same edge
    cyc("R10 commit+write", 1'b0, 1'b1, 1'b1, 0, 8'h55, 1'b1);
    cyc("R10 run B", 1'b1);
    cyc("R10 commit new", 1'b0, 1'b0, 1'b1, 0, 8'h0, 1'b1);
    repeat (2) cyc("R10 run B2", 1'b1);

    // R9: B = A + offset, selected for one clock
    load("R9 load B", 1'b0, 1'b1, 48'h0123_4567_89AB + 48'h0000_0100_0000);
    cyc("R9 commit B", 1'b0, 1'b0, 1'b1, 0, 8'h0, 1'b1);
    base = phase;
    cyc("R9 hop", 1'b1);
    repeat (3) cyc("R9 after hop", 1'b0);
    hop = phase - (base + ACC_W'(48'h0123_4567_89AB * 4));
    chk("R9 phase offset", hop, 48'h0000_0100_0000);

    // R4: alternate every clock
    for (int i = 0; i < 12; i++) cyc("R4 toggle", i[0]);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule